// File: doc/BRIEF.md
# Stop-State Wake and Reset-Status Controller

This block runs a microcontroller's low-power halt state and the way out of it. A stop request moves it from running into the halted state. At that moment it takes a snapshot of the synchronised GPIO levels. While halted, it watches the enabled pins for a change in either direction against that snapshot. It also watches the comparator interrupt when the comparator is armed for the halted state. Either source starts a fixed recovery delay. When the delay ends, the block returns to running and emits a one-clock wake pulse. If a comparator wake is waiting and its interrupt is enabled, the comparator interrupt is forwarded in that same cycle.

The port input-data register is frozen while the block is halted or recovering. When running resumes, it loads the current synchronised pin levels. A pin that has already settled back to its old level is therefore neither recorded nor reported as a pin interrupt. The external active-low reset pin goes through a glitch filter. A low that lasts long enough requests a system reset, and that request overrides any wake-up in progress.

A status read port reports three things: a halt-recovery flag, a reset-pin cause flag and the live low-voltage status. A low-voltage interrupt pulses on each rising edge of the gated low-voltage comparator.

Top module: `stopWakeCtrl`

## Requirements
- R1: After power-on reset, `stopped`, `wakePulse`, `sysRstReq`, `pinIrq`, `cmpIrqOut`, `lvdIrq`, `lvdStatus` and every `rdData` bit read 0.
- R2: `stopReq` while running makes `stopped` read 1 one clock later. A later change on a pin whose `wakeEn` bit is 0 leaves the block halted.
- R3: While running, pin changes and comparator interrupts never start recovery and never produce `wakePulse`. Pin changes still update `portData` and pulse `pinIrq`.
- R4: While halted, a change in either direction on an enabled pin starts recovery. `wakePulse` is high for exactly one clock, `RECOVERY_CYCLES`+3 clocks after the pin changes: two synchroniser stages, one detection clock, then the delay.
- R5: While halted, `cmpIrq` with `cmpStopEn`=1 starts recovery and sets the halt-recovery flag. `cmpIrqOut` pulses in the same clock as `wakePulse` only when `cmpIrqEn`=1. With `cmpStopEn`=0 the block stays halted.
- R6: `portData` stays frozen while halted or recovering. After recovery it loads the pin levels. A pin whose level reverted during recovery is not recorded and does not pulse `pinIrq`. A pin that holds its new level is recorded, and its `pinIrq` bit pulses.
- R7: `extRstN` held low for at least `RST_MIN_LOW` clocks gives exactly one `sysRstReq` pulse. A low of `RST_MIN_LOW`-1 clocks gives none.
- R8: A filtered reset during recovery aborts it: no `wakePulse` follows, `stopped` returns to 0, the halt-recovery flag clears and the reset-pin cause flag sets.
- R9: Status word layout: bit 0 is the halt-recovery flag, bit 1 is the reset-pin cause flag, bit 2 is the low-voltage status, and the other bits are 0. A clock with `rdEn`=1 clears bits 0 and 1.
- R10: `lvdStatus` and status bit 2 follow the synchronised `lvdRaw` gated by `lvdEnable`, with no latching. A read does not clear them.
- R11: With `lvdIrqEn`=1, each rising edge of the gated low-voltage status gives one `lvdIrq` pulse, even for a one-clock excursion. With `lvdIrqEn`=0 there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| stopReq | input | 1 | Request to enter the halted state |
| wakeEn | input | NUM_PINS | Per-pin wake enable |
| pinIn | input | NUM_PINS | Raw GPIO levels |
| cmpIrq | input | 1 | Comparator interrupt request |
| cmpStopEn | input | 1 | Comparator may wake the block while halted |
| cmpIrqEn | input | 1 | Comparator interrupt enable towards the CPU |
| extRstN | input | 1 | External active-low reset pin |
| lvdRaw | input | 1 | Low-voltage comparator output |
| lvdEnable | input | 1 | Power-control bit enabling the low-voltage detector |
| lvdIrqEn | input | 1 | Low-voltage interrupt enable |
| rdEn | input | 1 | Status read strobe |
| stopped | output | 1 | High while halted or recovering |
| wakePulse | output | 1 | One-clock pulse when recovery completes |
| sysRstReq | output | 1 | One-clock system-reset request |
| portData | output | NUM_PINS | Port input-data register |
| pinIrq | output | NUM_PINS | Per-pin change interrupt pulses |
| cmpIrqOut | output | 1 | Comparator interrupt to the CPU |
| lvdStatus | output | 1 | Live low-voltage status |
| lvdIrq | output | 1 | Low-voltage interrupt pulse |
| rdData | output | 8 | Status word, valid while rdEn is high |

## Verification
The wake function is exercised with several stimulus patterns:
- An enabled pin rising and held, while a disabled pin also changes. This separates the per-pin enable from the edge detector and measures the exact recovery latency.
- A three-clock pin pulse that returns before recovery ends. This separates a wake from a capture.
- Comparator wakes with the stop and interrupt enables in each combination.
- A reset-pin low that starts together with a pin wake. This shows the reset winning over a recovery in progress.

Reset lows one clock short of and exactly at the filter length bracket the glitch filter. Low-voltage excursions of one clock and of many clocks, with the detector disabled and enabled, separate the live status from the interrupt edge.

// File: rtl/stopWakePkg.sv
package stopWakePkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STOP    = 2'd1,
    ST_RECOVER = 2'd2
  } pwrState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic takeRef;       // snapshot pin levels on halt entry
    logic beginRecover;  // a wake source was accepted
    logic endRecover;    // recovery delay finished
    logic sysReset;      // filtered reset pin fired
    logic portLive;      // port capture enabled (running)
    logic statusRead;    // status read clears flags
  } ctlStrobes_t;

endpackage

// File: rtl/stopWakeSync.sv
module stopWakeSync #(
  parameter int   WIDTH    = 1,
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= {WIDTH{RST_LEVEL}};
      syncOut <= {WIDTH{RST_LEVEL}};
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/stopWakeCtl.sv
module stopWakeCtl
  import stopWakePkg::*;
#(
  parameter int RECOVERY_CYCLES = 64,
  parameter int RST_MIN_LOW     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReq,
  input  logic        wakeHit,
  input  logic        extRstN,
  input  logic        rdEn,
  output ctlStrobes_t strobes,
  output logic        stopped,
  output logic        wakePulse,
  output logic        sysRstReq
);

  localparam int RW = (RECOVERY_CYCLES > 1) ? $clog2(RECOVERY_CYCLES) : 1;
  localparam int LW = $clog2(RST_MIN_LOW + 1);
  localparam logic [RW-1:0] REC_LOAD  = RW'(RECOVERY_CYCLES - 1);
  localparam logic [LW-1:0] LOW_LAST  = LW'(RST_MIN_LOW - 1);
  localparam logic [LW-1:0] LOW_SAT   = LW'(RST_MIN_LOW);

  pwrState_t   state, nextState;
  logic [RW-1:0] recCnt;
  logic [LW-1:0] lowCnt;
  logic        extRstSync;
  logic        rstLow;
  logic        filterFire;

  stopWakeSync #(.WIDTH(1), .RST_LEVEL(1'b1)) u_rstSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extRstN),
    .syncOut (extRstSync)
  );

  assign rstLow     = ~extRstSync;
  assign filterFire = rstLow && (lowCnt == LOW_LAST);

  // Glitch filter: count consecutive low clocks, saturate after firing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (!rstLow)       lowCnt <= '0;
    else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    nextState          = state;
    strobes            = '0;
    strobes.portLive   = (state == ST_RUN);
    strobes.statusRead = rdEn;
    if (filterFire) begin
      strobes.sysReset = 1'b1;
      nextState        = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: if (stopReq) begin
          strobes.takeRef = 1'b1;
          nextState       = ST_STOP;
        end
        ST_STOP: if (wakeHit) begin
          strobes.beginRecover = 1'b1;
          nextState            = ST_RECOVER;
        end
        ST_RECOVER: if (recCnt == '0) begin
          strobes.endRecover = 1'b1;
          nextState          = ST_RUN;
        end
        default: nextState = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      recCnt    <= '0;
      wakePulse <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      state     <= nextState;
      wakePulse <= strobes.endRecover;
      sysRstReq <= strobes.sysReset;
      if (strobes.beginRecover)                   recCnt <= REC_LOAD;
      else if (state == ST_RECOVER && recCnt != '0) recCnt <= recCnt - 1'b1;
    end
  end

  assign stopped = (state != ST_RUN);

  // R4
  rec_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && recCnt != '0 && !filterFire) |=> (recCnt == $past(recCnt) - RW'(1)));

  // R3
  wake_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && $past(state) != ST_RECOVER) |-> ($past(state) == ST_STOP));

  // R7
  rst_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(rstLow));

  // R8
  rst_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> (state == ST_RUN && !wakePulse));

endmodule

// File: rtl/stopWakeDp.sv
module stopWakeDp
  import stopWakePkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [NUM_PINS-1:0] wakeEn,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                cmpIrq,
  input  logic                cmpStopEn,
  input  logic                cmpIrqEn,
  input  logic                lvdRaw,
  input  logic                lvdEnable,
  input  logic                lvdIrqEn,
  output logic                wakeHit,
  output logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] pinIrq,
  output logic                cmpIrqOut,
  output logic                lvdStatus,
  output logic                lvdIrq,
  output logic [7:0]          statusWord
);

  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] refLvl;
  logic                lvdSync;
  logic                lvdNow, lvdPrev;
  logic                pinHit, cmpHit;
  logic                pendCmp;
  logic                stopFlag, rstCause;

  stopWakeSync #(.WIDTH(NUM_PINS), .RST_LEVEL(1'b0)) u_pinSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  stopWakeSync #(.WIDTH(1), .RST_LEVEL(1'b0)) u_lvdSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (lvdRaw),
    .syncOut (lvdSync)
  );

  // Either-edge detection against the levels captured on halt entry
  assign pinHit  = |((pinSync ^ refLvl) & wakeEn);
  assign cmpHit  = cmpIrq & cmpStopEn;
  assign wakeHit = pinHit | cmpHit;

  assign lvdNow  = lvdSync & lvdEnable;
  assign lvdStatus = lvdNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLvl    <= '0;
      portData  <= '0;
      pinIrq    <= '0;
      pendCmp   <= 1'b0;
      cmpIrqOut <= 1'b0;
      stopFlag  <= 1'b0;
      rstCause  <= 1'b0;
      lvdPrev   <= 1'b0;
      lvdIrq    <= 1'b0;
    end else begin
      if (strobes.takeRef) refLvl <= pinSync;

      if (strobes.portLive) begin
        portData <= pinSync;
        pinIrq   <= pinSync ^ portData;
      end else begin
        pinIrq   <= '0;
      end

      if (strobes.sysReset)          pendCmp <= 1'b0;
      else if (strobes.beginRecover) pendCmp <= cmpHit;

      if (strobes.endRecover) cmpIrqOut <= pendCmp & cmpIrqEn;
      else                    cmpIrqOut <= strobes.portLive & cmpIrq & cmpIrqEn;

      if (strobes.sysReset)          stopFlag <= 1'b0;
      else if (strobes.beginRecover) stopFlag <= 1'b1;
      else if (strobes.statusRead)   stopFlag <= 1'b0;

      if (strobes.sysReset)        rstCause <= 1'b1;
      else if (strobes.statusRead) rstCause <= 1'b0;

      lvdPrev <= lvdNow;
      lvdIrq  <= lvdIrqEn & lvdNow & ~lvdPrev;
    end
  end

  assign statusWord = {5'b0, lvdNow, rstCause, stopFlag};

  // R6
  port_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.portLive |=> $stable(portData));

  // R6
  pin_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinIrq != '0) |-> $past(strobes.portLive));

  // R9
  stop_flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopFlag) |-> $past(strobes.beginRecover));

  // R11
  lvd_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lvdIrq |=> !lvdIrq);

  // R5
  cmp_after_rec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpIrqOut && !$past(strobes.portLive)) |-> $past(strobes.endRecover));

endmodule

// File: rtl/stopWakeCtrl.sv
module stopWakeCtrl
  import stopWakePkg::*;
#(
  parameter int NUM_PINS        = 8,
  parameter int RECOVERY_CYCLES = 64,
  parameter int RST_MIN_LOW     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopReq,
  input  logic [NUM_PINS-1:0] wakeEn,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                cmpIrq,
  input  logic                cmpStopEn,
  input  logic                cmpIrqEn,
  input  logic                extRstN,
  input  logic                lvdRaw,
  input  logic                lvdEnable,
  input  logic                lvdIrqEn,
  input  logic                rdEn,
  output logic                stopped,
  output logic                wakePulse,
  output logic                sysRstReq,
  output logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] pinIrq,
  output logic                cmpIrqOut,
  output logic                lvdStatus,
  output logic                lvdIrq,
  output logic [7:0]          rdData
);

  ctlStrobes_t strobes;
  logic        wakeHit;
  logic [7:0]  statusWord;

  stopWakeCtl #(
    .RECOVERY_CYCLES (RECOVERY_CYCLES),
    .RST_MIN_LOW     (RST_MIN_LOW)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stopReq   (stopReq),
    .wakeHit   (wakeHit),
    .extRstN   (extRstN),
    .rdEn      (rdEn),
    .strobes   (strobes),
    .stopped   (stopped),
    .wakePulse (wakePulse),
    .sysRstReq (sysRstReq)
  );

  stopWakeDp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wakeEn     (wakeEn),
    .pinIn      (pinIn),
    .cmpIrq     (cmpIrq),
    .cmpStopEn  (cmpStopEn),
    .cmpIrqEn   (cmpIrqEn),
    .lvdRaw     (lvdRaw),
    .lvdEnable  (lvdEnable),
    .lvdIrqEn   (lvdIrqEn),
    .wakeHit    (wakeHit),
    .portData   (portData),
    .pinIrq     (pinIrq),
    .cmpIrqOut  (cmpIrqOut),
    .lvdStatus  (lvdStatus),
    .lvdIrq     (lvdIrq),
    .statusWord (statusWord)
  );

  assign rdData = rdEn ? statusWord : 8'h00;

endmodule

// File: tb/stopWakeCtrl_tb.sv
`timescale 1ns/1ps
module stopWakeCtrl_tb;

  localparam int NP  = 8;
  localparam int REC = 64;
  localparam int RML = 8;

  localparam int K_RST  = 0;
  localparam int K_WAKE = 1;
  localparam int K_CMP  = 2;
  localparam int K_PIN  = 3;
  localparam int K_LVD  = 4;

  typedef struct {
    int         kind;
    logic [7:0] data;
    string      req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0;
  logic [NP-1:0] wakeEn = '0;
  logic [NP-1:0] pinIn = '0;
  logic cmpIrq = 1'b0, cmpStopEn = 1'b0, cmpIrqEn = 1'b0;
  logic extRstN = 1'b1;
  logic lvdRaw = 1'b0, lvdEnable = 1'b0, lvdIrqEn = 1'b0;
  logic rdEn = 1'b0;
  logic stopped, wakePulse, sysRstReq, cmpIrqOut, lvdStatus, lvdIrq;
  logic [NP-1:0] portData, pinIrq;
  logic [7:0] rdData;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  stopWakeCtrl #(.NUM_PINS(NP), .RECOVERY_CYCLES(REC), .RST_MIN_LOW(RML)) u_dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .wakeEn(wakeEn), .pinIn(pinIn),
    .cmpIrq(cmpIrq), .cmpStopEn(cmpStopEn), .cmpIrqEn(cmpIrqEn), .extRstN(extRstN),
    .lvdRaw(lvdRaw), .lvdEnable(lvdEnable), .lvdIrqEn(lvdIrqEn), .rdEn(rdEn),
    .stopped(stopped), .wakePulse(wakePulse), .sysRstReq(sysRstReq),
    .portData(portData), .pinIrq(pinIrq), .cmpIrqOut(cmpIrqOut),
    .lvdStatus(lvdStatus), .lvdIrq(lvdIrq), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushExp(input int kind, input logic [7:0] data, input string req);
    expItem_t it;
    it.kind = kind; it.data = data; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic popCheck(input int kind, input logic [7:0] data);
    expItem_t it;
    vectors++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: actual kind %0d data %0h expected none", kind, data);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.data !== data) begin
        fails++;
        $display("FAIL %s: actual kind %0d data %0h expected kind %0d data %0h",
                 it.req, kind, data, it.kind, it.data);
      end
    end
  endtask

  // Monitor: events are compared in a fixed order within one clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (sysRstReq)   popCheck(K_RST, 8'h00);
      if (wakePulse)   popCheck(K_WAKE, 8'h00);
      if (cmpIrqOut)   popCheck(K_CMP, 8'h00);
      if (pinIrq != 0) popCheck(K_PIN, pinIrq);
      if (lvdIrq)      popCheck(K_LVD, 8'h00);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readStatus(output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic enterStop(input string req);
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(req, stopped, 1'b1);
  endtask

  task automatic waitWake(input string req, output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (wakePulse) break;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    int n;
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R1: reset state
    check("R1 stopped", stopped, 1'b0);
    check("R1 wakePulse", wakePulse, 1'b0);
    check("R1 sysRstReq", sysRstReq, 1'b0);
    check("R1 lvdStatus", lvdStatus, 1'b0);
    readStatus(st);
    check("R1 status", st, 8'h00);

    // R3: running, pin changes give pin irqs but no wake
    wakeEn = '1;
    cmpStopEn = 1'b1;
    pushExp(K_PIN, 8'h01, "R3 pin irq while running");
    @(negedge clk); pinIn = 8'h01;
    @(negedge clk); cmpIrq = 1'b1;
    @(negedge clk); cmpIrq = 1'b0;
    tick(10);
    check("R3 no halt", stopped, 1'b0);
    check("R3 portData", portData, 8'h01);
    pushExp(K_PIN, 8'h01, "R3 pin fall while running");
    pinIn = 8'h00;
    tick(6);
    cmpStopEn = 1'b0;

    // R2/R4/R6: disabled pin ignored, enabled pin held, latency
    wakeEn = 8'h04;
    enterStop("R2 enter halt");
    pinIn = 8'h02;
    tick(12);
    check("R2 disabled pin ignored", stopped, 1'b1);
    check("R6 frozen while halted", portData, 8'h00);
    pushExp(K_WAKE, 8'h00, "R4 wake");
    pushExp(K_PIN, 8'h06, "R6 held levels reported");
    pinIn = 8'h06;
    waitWake("R4", n);
    check("R4 wake latency", n, REC + 3);
    tick(3);
    check("R6 held level captured", portData, 8'h06);
    check("R2 running again", stopped, 1'b0);
    readStatus(st);
    check("R9 halt flag set", st, 8'h01);
    readStatus(st);
    check("R9 read clears", st, 8'h00);
    pushExp(K_PIN, 8'h06, "R3 pins back");
    pinIn = 8'h00;
    tick(6);

    // R6: short pulse wakes, not recorded
    wakeEn = '1;
    enterStop("R6 enter halt");
    pushExp(K_WAKE, 8'h00, "R6 short pulse wake");
    pinIn = 8'h08;
    tick(3);
    pinIn = 8'h00;
    waitWake("R6", n);
    check("R4 falling-back pulse wakes", wakePulse, 1'b1);
    tick(5);
    check("R6 short pulse not captured", portData, 8'h00);
    readStatus(st);
    check("R9 flag after short wake", st, 8'h01);

    // R5: comparator wake with irq enabled
    cmpStopEn = 1'b1; cmpIrqEn = 1'b1;
    enterStop("R5 enter halt");
    pushExp(K_WAKE, 8'h00, "R5 cmp wake");
    pushExp(K_CMP, 8'h00, "R5 cmp irq after recovery");
    cmpIrq = 1'b1;
    @(negedge clk); cmpIrq = 1'b0;
    waitWake("R5", n);
    tick(3);
    readStatus(st);
    check("R5 halt flag from comparator", st, 8'h01);

    // R5: comparator not armed for halt
    cmpStopEn = 1'b0;
    enterStop("R5 enter halt unarmed");
    cmpIrq = 1'b1;
    @(negedge clk); cmpIrq = 1'b0;
    tick(20);
    check("R5 unarmed comparator ignored", stopped, 1'b1);
    pushExp(K_WAKE, 8'h00, "R5 exit by pin");
    pushExp(K_PIN, 8'h01, "R5 exit pin recorded");
    pinIn = 8'h01;
    waitWake("R5", n);
    tick(3);
    pushExp(K_PIN, 8'h01, "R5 pin back");
    pinIn = 8'h00;
    tick(6);
    readStatus(st);

    // R5: comparator wake without irq enable
    cmpStopEn = 1'b1; cmpIrqEn = 1'b0;
    enterStop("R5 enter halt no irq");
    pushExp(K_WAKE, 8'h00, "R5 wake without cmp irq");
    cmpIrq = 1'b1;
    @(negedge clk); cmpIrq = 1'b0;
    waitWake("R5", n);
    tick(3);
    readStatus(st);
    cmpStopEn = 1'b0;

    // R7: glitch filter boundary
    extRstN = 1'b0; tick(RML - 1); extRstN = 1'b1;
    tick(8);
    readStatus(st);
    check("R7 short low rejected", st, 8'h00);
    pushExp(K_RST, 8'h00, "R7 reset request");
    extRstN = 1'b0; tick(RML); extRstN = 1'b1;
    tick(8);
    readStatus(st);
    check("R7 reset cause set", st, 8'h02);
    readStatus(st);
    check("R9 cause cleared by read", st, 8'h00);

    // R8: reset during recovery wins
    wakeEn = 8'h01;
    enterStop("R8 enter halt");
    pushExp(K_RST, 8'h00, "R8 reset during recovery");
    pushExp(K_PIN, 8'h01, "R8 pin after reset");
    pinIn = 8'h01; extRstN = 1'b0;
    tick(12);
    extRstN = 1'b1;
    check("R8 running after reset", stopped, 1'b0);
    tick(REC + 10);
    readStatus(st);
    check("R8 status after abort", st, 8'h02);
    pushExp(K_PIN, 8'h01, "R8 pin back");
    pinIn = 8'h00;
    tick(6);

    // R10/R11: low-voltage status and interrupt
    lvdIrqEn = 1'b1;
    lvdRaw = 1'b1;
    tick(5);
    check("R10 disabled detector", lvdStatus, 1'b0);
    lvdRaw = 1'b0;
    tick(3);
    lvdEnable = 1'b1;
    pushExp(K_LVD, 8'h00, "R11 lvd irq");
    lvdRaw = 1'b1;
    tick(5);
    check("R10 live status", lvdStatus, 1'b1);
    readStatus(st);
    check("R10 status bit2", st, 8'h04);
    readStatus(st);
    check("R10 not cleared by read", st, 8'h04);
    lvdRaw = 1'b0;
    tick(5);
    check("R10 follows comparator", lvdStatus, 1'b0);
    pushExp(K_LVD, 8'h00, "R11 transient caught");
    lvdRaw = 1'b1;
    @(negedge clk); lvdRaw = 1'b0;
    tick(6);
    lvdIrqEn = 1'b0;
    lvdRaw = 1'b1;
    @(negedge clk); lvdRaw = 1'b0;
    tick(6);

    check("R11 all expected events seen", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule